// File: doc/BRIEF.md
# SPI Master FIFO and Status Unit

This unit sits between a simple register bus and the frame engine of an SPI master. Software writes command words into a transmit queue through a data port. The engine takes them one at a time with a request strobe. Words the engine receives are collected in a receive queue, and software drains that queue by reading the same data port. Both queues are small first-in first-out buffers with a parameterized depth (four entries by default).

A status word reports the following:
- the level of each queue;
- a fill request while the transmit queue has room;
- a drain request while the receive queue holds data;
- sticky event flags for transmit underflow, receive overflow, end of queue and transfer complete;
- a running bit.

Software clears a sticky flag by writing a one to its position. An enable word with the same bit positions masks the flags into a single registered interrupt line. A control word has four jobs:
- it holds the halt bit, which is set at reset and stops the unit from serving the engine;
- it selects what happens when a word arrives on a full receive queue: the new word is dropped, or it overwrites the oldest word;
- it has two write-only bits that flush the receive queue and the transmit queue.

Bus word addresses:
- 0: control;
- 1: status;
- 2: interrupt enable;
- 3: data port (write pushes a command, read pops a received word).

Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.

Top module: `spiq_fifo_status`

## Requirements
- R1: After reset, both queues are empty and the control word reads 0x0000_0001 (halt set). The status word reads 0x0200_0000, the enable word reads 0, and `irq` and `eng_cmd_vld` are low.
- R2: Each `eng_cmd_req` while not halted and the transmit queue is non-empty does two things in the next cycle: it presents the oldest pushed command on `eng_cmd_data` and pulses `eng_cmd_vld`. Commands come out in write order. While halted (control bit 0 = 1), requests are ignored: there is no pulse, no pop and no flag.
- R3: Status bits 15:12 hold the transmit queue level, and status bit 25 is high exactly when that queue is not full. A data-port write to a full transmit queue is discarded.
- R4: A data-port read returns the oldest received word, zero-extended, on `bus_rdata` in the next cycle and removes it from the queue. A read of an empty queue returns 0.
- R5: Status bits 7:4 hold the receive queue level, and status bit 17 is high exactly when that queue is not empty.
- R6: A word that arrives on a full receive queue, with no pop in the same cycle, sets status bit 19. With control bit 24 = 0 the new word is dropped. With control bit 24 = 1 it replaces the oldest word, so the level stays at the depth.
- R7: Status bit 27 is set when `eng_cmd_req` arrives while not halted and the transmit queue is empty.
- R8: A pulse on `eng_eoq` sets status bit 28, and a pulse on `eng_done` sets status bit 31. Status bit 30 reads as the inverse of the halt bit.
- R9: Writing the status word clears each of bits 19, 27, 28 and 31 that is written as one. Zeros have no effect, and writing ones to bits 17 and 25 has no effect. When a flag's event and its clear fall in the same cycle, the flag stays set.
- R10: Writing control bit 10 empties the receive queue, and writing control bit 11 empties the transmit queue. Both bits read back as 0.
- R11: The enable word (address 2) uses bits 17, 19, 25, 27, 28 and 31. `irq` is the OR of each of those status bits ANDed with its enable, registered one cycle after the status state.
- R12: A received word and a data-port read in the same cycle on a full receive queue do not set the overflow flag. The read returns the oldest word, and the level stays at the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 enable, 3 data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| eng_cmd_req | input | 1 | Engine asks for the next command |
| eng_cmd_vld | output | 1 | Command valid on `eng_cmd_data` |
| eng_cmd_data | output | CMD_W | Command word to the engine |
| eng_rx_vld | input | 1 | Engine delivers a received word |
| eng_rx_data | input | RX_W | Received word |
| eng_eoq | input | 1 | End-of-queue event pulse |
| eng_done | input | 1 | Transfer-complete event pulse |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets the full-queue edges, and each check shows what a wrong design would do:
- A fifth command write that is not dropped shows up as a corrupted or extra word at the engine side.
- A reversed receive overflow policy returns the wrong surviving words after an overflow.
- A design that flags overflow on a simultaneous push and pop of a full queue reports a spurious bit 19.

It also probes the flag rules:
- Requests while halted must neither produce a command nor raise underflow.
- Clears written with zeros, or written to the level-type bits, must leave the status unchanged.
- An event that coincides with its own clear must survive.

The one-cycle interrupt latency and the masking of each source are checked cycle by cycle.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int ADDR_W      = 2;
  localparam int CNT_FIELD_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_IEN  = 2'd2,
    A_DATA = 2'd3
  } spiq_addr_e;

  // control word positions
  localparam int B_HALT     = 0;
  localparam int B_FLUSH_RX = 10;
  localparam int B_FLUSH_TX = 11;
  localparam int B_OVW      = 24;

  // status / enable positions
  localparam int B_DRAIN     = 17;
  localparam int B_OVF       = 19;
  localparam int B_FILL      = 25;
  localparam int B_UNF       = 27;
  localparam int B_EOQ       = 28;
  localparam int B_RUN       = 30;
  localparam int B_TC        = 31;
  localparam int RXCNT_LSB   = 4;
  localparam int TXCNT_LSB   = 12;

  // sticky flag indices
  localparam int F_OVF = 0;
  localparam int F_UNF = 1;
  localparam int F_EOQ = 2;
  localparam int F_TC  = 3;
  localparam int N_STICKY = 4;

  typedef struct packed {
    logic tc;
    logic eoq;
    logic unf;
    logic fill;
    logic ovf;
    logic drain;
  } spiq_irq_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  input  logic                         ovw_en,
  output logic [W-1:0]                 pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         pop_ok,
  output logic                         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push, do_ovw;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign count    = cnt;
  assign do_pop   = pop & ~empty & ~flush;
  assign do_push  = push & (~full | do_pop) & ~flush;
  assign overflow = push & full & ~do_pop & ~flush;
  assign do_ovw   = overflow & ovw_en;
  assign pop_ok   = do_pop;

  // storage and read port without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push | do_ovw)
      mem[wr_ptr] <= push_data;
    if (pop)
      pop_data <= do_pop ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push | do_ovw)
        wr_ptr <= step(wr_ptr);
      if (do_pop | do_ovw)
        rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spiq_flags.sv
module spiq_flags
  import spiq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [N_STICKY-1:0] set,
  input  logic [N_STICKY-1:0] clr,
  input  logic                fill_req,
  input  logic                drain_req,
  input  spiq_irq_t           ien,
  output logic [N_STICKY-1:0] sticky,
  output logic                irq
);
  // one sticky cell per event; a set in the same cycle as a clear wins
  for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        sticky[i] <= 1'b0;
      else if (set[i])
        sticky[i] <= 1'b1;
      else if (clr[i])
        sticky[i] <= 1'b0;
    end
  end

  spiq_irq_t src;
  always_comb begin
    src.tc    = sticky[F_TC];
    src.eoq   = sticky[F_EOQ];
    src.unf   = sticky[F_UNF];
    src.fill  = fill_req;
    src.ovf   = sticky[F_OVF];
    src.drain = drain_req;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= |(6'(src) & 6'(ien));
  end
endmodule

// File: rtl/spiq_fifo_status.sv
module spiq_fifo_status
  import spiq_pkg::*;
#(
  parameter int CMD_W = 16,
  parameter int RX_W  = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_cmd_req,
  output logic              eng_cmd_vld,
  output logic [CMD_W-1:0]  eng_cmd_data,
  input  logic              eng_rx_vld,
  input  logic [RX_W-1:0]   eng_rx_data,
  input  logic              eng_eoq,
  input  logic              eng_done,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic                halt, ovw_pol;
  spiq_irq_t           ien;
  logic [CW-1:0]       tx_cnt, rx_cnt;
  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic                tx_pop_ok, rx_pop_ok, tx_ovf_unused, rx_ovf;
  logic [RX_W-1:0]     rx_pop_data;
  logic [N_STICKY-1:0] sticky, set_v, clr_v;
  logic                wr_ctrl, wr_stat, wr_ien, wr_data, rd_data;
  logic                flush_rx, flush_tx, tx_pop, unf_evt;
  logic [31:0]         stat_w, ctrl_w, ien_w, rdata_q;
  logic                rd_pop_q;
  logic                unused_bits;

  assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
  assign wr_stat  = bus_wr & (bus_addr == A_STAT);
  assign wr_ien   = bus_wr & (bus_addr == A_IEN);
  assign wr_data  = bus_wr & (bus_addr == A_DATA);
  assign rd_data  = bus_rd & (bus_addr == A_DATA);
  assign flush_rx = wr_ctrl & bus_wdata[B_FLUSH_RX];
  assign flush_tx = wr_ctrl & bus_wdata[B_FLUSH_TX];
  assign tx_pop   = eng_cmd_req & ~halt;
  assign unf_evt  = tx_pop & tx_empty;
  assign unused_bits = ^bus_wdata;

  spiq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_tx),
    .push(wr_data), .push_data(bus_wdata[CMD_W-1:0]),
    .pop(tx_pop), .ovw_en(1'b0),
    .pop_data(eng_cmd_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty),
    .pop_ok(tx_pop_ok), .overflow(tx_ovf_unused)
  );

  spiq_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_rx),
    .push(eng_rx_vld), .push_data(eng_rx_data),
    .pop(rd_data), .ovw_en(ovw_pol),
    .pop_data(rx_pop_data), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty),
    .pop_ok(rx_pop_ok), .overflow(rx_ovf)
  );

  always_comb begin
    set_v        = '0;
    set_v[F_OVF] = rx_ovf;
    set_v[F_UNF] = unf_evt;
    set_v[F_EOQ] = eng_eoq;
    set_v[F_TC]  = eng_done;
    clr_v        = '0;
    if (wr_stat) begin
      clr_v[F_OVF] = bus_wdata[B_OVF];
      clr_v[F_UNF] = bus_wdata[B_UNF];
      clr_v[F_EOQ] = bus_wdata[B_EOQ];
      clr_v[F_TC]  = bus_wdata[B_TC];
    end
  end

  spiq_flags u_flags (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v),
    .fill_req(~tx_full), .drain_req(~rx_empty),
    .ien(ien), .sticky(sticky), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halt    <= 1'b1;
      ovw_pol <= 1'b0;
      ien     <= '0;
    end else begin
      if (wr_ctrl) begin
        halt    <= bus_wdata[B_HALT];
        ovw_pol <= bus_wdata[B_OVW];
      end
      if (wr_ien) begin
        ien.tc    <= bus_wdata[B_TC];
        ien.eoq   <= bus_wdata[B_EOQ];
        ien.unf   <= bus_wdata[B_UNF];
        ien.fill  <= bus_wdata[B_FILL];
        ien.ovf   <= bus_wdata[B_OVF];
        ien.drain <= bus_wdata[B_DRAIN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      eng_cmd_vld <= 1'b0;
    else
      eng_cmd_vld <= tx_pop_ok;
  end

  always_comb begin
    stat_w                              = '0;
    stat_w[B_TC]                        = sticky[F_TC];
    stat_w[B_RUN]                       = ~halt;
    stat_w[B_EOQ]                       = sticky[F_EOQ];
    stat_w[B_UNF]                       = sticky[F_UNF];
    stat_w[B_FILL]                      = ~tx_full;
    stat_w[B_OVF]                       = sticky[F_OVF];
    stat_w[B_DRAIN]                     = ~rx_empty;
    stat_w[TXCNT_LSB +: CNT_FIELD_W]    = CNT_FIELD_W'(tx_cnt);
    stat_w[RXCNT_LSB +: CNT_FIELD_W]    = CNT_FIELD_W'(rx_cnt);

    ctrl_w         = '0;
    ctrl_w[B_HALT] = halt;
    ctrl_w[B_OVW]  = ovw_pol;

    ien_w          = '0;
    ien_w[B_TC]    = ien.tc;
    ien_w[B_EOQ]   = ien.eoq;
    ien_w[B_UNF]   = ien.unf;
    ien_w[B_FILL]  = ien.fill;
    ien_w[B_OVF]   = ien.ovf;
    ien_w[B_DRAIN] = ien.drain;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rd_pop_q <= 1'b0;
    end else if (bus_rd) begin
      rd_pop_q <= (bus_addr == A_DATA);
      unique case (bus_addr)
        A_CTRL:  rdata_q <= ctrl_w;
        A_STAT:  rdata_q <= stat_w;
        A_IEN:   rdata_q <= ien_w;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_pop_q ? 32'(rx_pop_data) : rdata_q;
endmodule

// File: rtl/spiq_fifo_status_chk.sv
module spiq_fifo_status_chk
  import spiq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       eng_cmd_req,
  input logic                       eng_cmd_vld,
  input logic                       eng_rx_vld,
  input logic                       halt,
  input logic                       tx_empty,
  input logic                       rd_data,
  input logic                       flush_tx,
  input logic                       flush_rx,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic [N_STICKY-1:0]        sticky,
  input spiq_irq_t                  ien,
  input logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  // R3
  tx_level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CW'(DEPTH));

  // R2
  cmd_vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_vld |-> ($past(eng_cmd_req) && !$past(halt)));

  // R7
  unf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sticky[F_UNF]) |-> $past(eng_cmd_req && !halt && tx_empty));

  // R10
  tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush_tx |=> (tx_cnt == '0));

  // R12
  rx_full_pushpop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == CW'(DEPTH) && eng_rx_vld && rd_data && !flush_rx)
      |=> (rx_cnt == CW'(DEPTH)));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ien) == '0) |-> !irq);
endmodule

bind spiq_fifo_status spiq_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .eng_cmd_req(eng_cmd_req), .eng_cmd_vld(eng_cmd_vld),
  .eng_rx_vld(eng_rx_vld), .halt(halt), .tx_empty(tx_empty), .rd_data(rd_data),
  .flush_tx(flush_tx), .flush_rx(flush_rx), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .sticky(sticky), .ien(ien), .irq(irq)
);

// File: tb/sim_spiq_fifo_status.sv
`timescale 1ns/1ps
module sim_spiq_fifo_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_cmd_req = 1'b0;
  logic        eng_cmd_vld;
  logic [15:0] eng_cmd_data;
  logic        eng_rx_vld = 1'b0;
  logic [15:0] eng_rx_data = '0;
  logic        eng_eoq = 1'b0, eng_done = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [15:0] exp_cmd [$];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  spiq_fifo_status #(.CMD_W(16), .RX_W(16), .DEPTH(4)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_cmd_req(eng_cmd_req),
    .eng_cmd_vld(eng_cmd_vld), .eng_cmd_data(eng_cmd_data), .eng_rx_vld(eng_rx_vld),
    .eng_rx_data(eng_rx_data), .eng_eoq(eng_eoq), .eng_done(eng_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] r;
    rd(a, r);
    chk(tag, r, exp);
  endtask

  task automatic push_cmd(input logic [15:0] d, input bit kept);
    wr(2'd3, {16'h0, d});
    if (kept) exp_cmd.push_back(d);
  endtask

  task automatic cmd_req();
    eng_cmd_req = 1'b1;
    tick();
    eng_cmd_req = 1'b0;
  endtask

  task automatic rx_in(input logic [15:0] d);
    eng_rx_vld = 1'b1; eng_rx_data = d;
    tick();
    eng_rx_vld = 1'b0;
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor for the command path (R2)
  always @(negedge clk) begin
    if (!rst && eng_cmd_vld) begin
      checks++;
      if (exp_cmd.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected command act=%h exp=none", eng_cmd_data);
      end else begin
        logic [15:0] e;
        e = exp_cmd.pop_front();
        if (eng_cmd_data !== e) begin
          fails++;
          $display("FAIL R2 command order act=%h exp=%h", eng_cmd_data, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_up();
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 cmd_vld", {31'h0, eng_cmd_vld}, 32'h0);
    chk_reg("R1 status", 2'd1, 32'h0200_0000);
    chk_reg("R1 control", 2'd0, 32'h0000_0001);
    chk_reg("R1 enable", 2'd2, 32'h0);

    // R8 running follows halt
    wr(2'd0, 32'h0);
    chk_reg("R8 running", 2'd1, 32'h4200_0000);

    // R2 / R3 order and level
    push_cmd(16'h00A1, 1);
    push_cmd(16'h00B2, 1);
    push_cmd(16'h00C3, 1);
    chk_reg("R3 tx level 3", 2'd1, 32'h4200_3000);
    repeat (3) cmd_req();
    tick();
    chk("R2 all delivered", exp_cmd.size(), 0);

    // R3 full queue drops fifth write
    for (int i = 0; i < 5; i++) push_cmd(16'hD000 + 16'(i), i < 4);
    chk_reg("R3 tx full", 2'd1, 32'h4000_4000);
    repeat (4) cmd_req();
    tick();
    chk("R3 dropped write absent", exp_cmd.size(), 0);
    chk_reg("R3 tx empty again", 2'd1, 32'h4200_0000);

    // R7 underflow
    cmd_req();
    chk("R7 no command on empty", {31'h0, eng_cmd_vld}, 32'h0);
    chk_reg("R7 underflow flag", 2'd1, 32'h4A00_0000);

    // R9 write-one-to-clear
    wr(2'd1, 32'h0);
    chk_reg("R9 zeros no effect", 2'd1, 32'h4A00_0000);
    wr(2'd1, 32'h0202_0000);
    chk_reg("R9 level bits no effect", 2'd1, 32'h4A00_0000);
    wr(2'd1, 32'h0800_0000);
    chk_reg("R9 clear underflow", 2'd1, 32'h4200_0000);

    // R2 halted requests ignored
    wr(2'd0, 32'h0000_0001);
    push_cmd(16'h0055, 0);
    cmd_req();
    chk("R2 halted no vld", {31'h0, eng_cmd_vld}, 32'h0);
    chk_reg("R2 halted no pop", 2'd1, 32'h0200_1000);
    // R10 transmit flush
    wr(2'd0, 32'h0000_0801);
    chk_reg("R10 tx flushed", 2'd1, 32'h0200_0000);
    chk_reg("R10 flush reads zero", 2'd0, 32'h0000_0001);
    cmd_req();
    chk("R7 halted no underflow", {31'h0, eng_cmd_vld}, 32'h0);
    chk_reg("R7 halted status", 2'd1, 32'h0200_0000);
    wr(2'd0, 32'h0);

    // R4 / R5 receive path
    rx_in(16'h0011); rx_in(16'h0022); rx_in(16'h0033);
    chk_reg("R5 rx level 3", 2'd1, 32'h4202_0030);
    rd(2'd3, v); chk("R4 pop 1", v, 32'h0011);
    rd(2'd3, v); chk("R4 pop 2", v, 32'h0022);
    rx_in(16'h0044); rx_in(16'h0055);
    rd(2'd3, v); chk("R4 pop 3", v, 32'h0033);
    rd(2'd3, v); chk("R4 pop 4", v, 32'h0044);
    rd(2'd3, v); chk("R4 pop 5", v, 32'h0055);
    rd(2'd3, v); chk("R4 pop empty", v, 32'h0);
    chk_reg("R5 rx empty", 2'd1, 32'h4200_0000);

    // R6 drop policy
    for (int i = 0; i < 5; i++) rx_in(16'hA000 + 16'(i));
    chk_reg("R6 drop overflow", 2'd1, 32'h420A_0040);
    for (int i = 0; i < 4; i++) begin
      rd(2'd3, v); chk("R6 drop keeps oldest", v, 32'hA000 + 32'(i));
    end
    wr(2'd1, 32'h0008_0000);

    // R6 overwrite policy
    wr(2'd0, 32'h0100_0000);
    chk_reg("R6 policy readback", 2'd0, 32'h0100_0000);
    for (int i = 0; i < 5; i++) rx_in(16'hB000 + 16'(i));
    chk_reg("R6 overwrite overflow", 2'd1, 32'h420A_0040);
    for (int i = 1; i < 5; i++) begin
      rd(2'd3, v); chk("R6 overwrite keeps newest", v, 32'hB000 + 32'(i));
    end
    wr(2'd1, 32'h0008_0000);

    // R12 push and pop together on full queue
    for (int i = 0; i < 4; i++) rx_in(16'hC000 + 16'(i));
    eng_rx_vld = 1'b1; eng_rx_data = 16'hC004;
    bus_rd = 1'b1; bus_addr = 2'd3;
    tick();
    eng_rx_vld = 1'b0; bus_rd = 1'b0;
    chk("R12 oldest returned", bus_rdata, 32'hC000);
    chk_reg("R12 no overflow", 2'd1, 32'h4202_0040);
    for (int i = 1; i < 5; i++) begin
      rd(2'd3, v); chk("R12 order", v, 32'hC000 + 32'(i));
    end

    // R10 receive flush
    rx_in(16'h0077); rx_in(16'h0088);
    wr(2'd0, 32'h0100_0400);
    chk_reg("R10 rx flushed", 2'd1, 32'h4200_0000);

    // R8 event flags
    eng_eoq = 1'b1; tick(); eng_eoq = 1'b0;
    chk_reg("R8 eoq", 2'd1, 32'h5200_0000);
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk_reg("R8 done", 2'd1, 32'hD200_0000);
    // R9 set beats clear
    eng_done = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h8000_0000;
    tick();
    eng_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    chk_reg("R9 set wins", 2'd1, 32'hD200_0000);
    wr(2'd1, 32'h9000_0000);
    chk_reg("R9 clear both", 2'd1, 32'h4200_0000);

    // R11 interrupt masking and latency
    wr(2'd2, 32'h0200_0000);
    chk("R11 latency", {31'h0, irq}, 32'h0);
    tick();
    chk("R11 fill irq", {31'h0, irq}, 32'h1);
    chk_reg("R11 enable readback", 2'd2, 32'h0200_0000);
    wr(2'd2, 32'h1000_0000);
    tick();
    chk("R11 fill masked", {31'h0, irq}, 32'h0);
    eng_eoq = 1'b1; tick(); eng_eoq = 1'b0;
    tick();
    chk("R11 eoq irq", {31'h0, irq}, 32'h1);
    wr(2'd1, 32'h1000_0000);
    tick();
    chk("R11 eoq cleared", {31'h0, irq}, 32'h0);
    wr(2'd2, 32'h0002_0000);
    tick();
    chk("R11 drain masked empty", {31'h0, irq}, 32'h0);

    repeat (2) tick();
    finish_up();
  end
endmodule